// File: doc/BRIEF.md
# Rotating Four-Slot Sector Read Pipeline

This block sits behind a flash controller that has already opened a page and now streams its bytes. On a start request it pulls a chosen number of sectors from the flash byte stream. Each sector is 512 data bytes followed by 16 check-code bytes. The sectors go into four rotating slots, and each one is then replayed on an output byte stream with a valid/ready handshake. Sector k always lands in slot k mod 4.

Filling and draining run at the same time. Once a fill finishes, the next fill may start while the finished slot is drained. A fill never targets a slot whose sector has not yet been fully drained, so up to four sectors can wait in the slots while the sink stalls. A check-engine enable is captured when a run is accepted and is presented on an output for the whole run; the block itself does nothing with it.

Top module: `sector_read_pipe`

## Requirements
- R1: After reset, `busy`, `nand_ready`, `out_valid`, `done` and `chk_en` are all low.
- R2: A start pulse is accepted only while idle and only with a sector count from 1 to 8. Any other count is ignored and `busy` stays low.
- R3: A start pulse during a run is ignored. The run in progress keeps its sector count.
- R4: `chk_en` takes the value of `chk_en_req` when a start is accepted. It does not change until the next accepted start.
- R5: A flash byte is taken when `nand_valid` and `nand_ready` are both high. Each sector takes 528 bytes: 512 data bytes, then 16 check bytes. Sector k is stored in slot k mod 4.
- R6: Each output sector is 528 bytes. `out_spare` is high on the last 16 bytes only, `out_last` is high on byte 527 only, and `out_sector` (3 bits) carries the sector index counted from 0.
- R7: Sectors leave in the order they arrived, and every output byte equals the flash byte at the same position in the run.
- R8: The fill of the next sector may run while an earlier sector is being drained.
- R9: A fill never enters a slot that is still undrained. At any time, the flash bytes taken never exceed 528 times (sectors fully drained + 4).
- R10: A run takes exactly count × 528 flash bytes. `nand_ready` stays low outside a fill.
- R11: `done` is a one-cycle pulse in the cycle after the final check byte is handshaken. `busy` is low in that same cycle.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a run |
| sec_count | input | 4 | Sectors to move, 1 to 8 |
| chk_en_req | input | 1 | Check-engine enable to capture at start |
| busy | output | 1 | Run in progress |
| chk_en | output | 1 | Captured check-engine enable |
| nand_data | input | 8 | Flash byte stream data |
| nand_valid | input | 1 | Flash byte present |
| nand_ready | output | 1 | Block accepts a flash byte |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Sink accepts the output byte |
| out_spare | output | 1 | Output byte is a check byte |
| out_last | output | 1 | Output byte ends its sector |
| out_sector | output | 3 | Sector index of the output byte |
| done | output | 1 | Run finished |

## Verification
The hardest state to reach is the one where all four slots hold undrained sectors and the fill must wait for the drain. Random handshakes almost never produce it, because a drain keeps up with a fill after only a few hundred cycles. The stimulus therefore holds `out_ready` low for thousands of cycles on an eight-sector run while the flash side streams freely. It then checks that intake stops at exactly four sectors, and lets the run finish under random backpressure.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // slot that sector number idx occupies
  function automatic int unsigned slot_of(int unsigned idx, int unsigned slots);
    return idx % slots;
  endfunction

  // flat byte address inside the slot store
  function automatic int unsigned byte_addr(int unsigned slot, int unsigned off,
                                            int unsigned sect_bytes);
    return slot * sect_bytes + off;
  endfunction

  // check bytes follow the data bytes inside a sector
  function automatic bit in_spare(int unsigned off, int unsigned data_bytes);
    return off >= data_bytes;
  endfunction

  function automatic bit sector_end(int unsigned off, int unsigned sect_bytes);
    return off == sect_bytes - 1;
  endfunction

  // sectors filled but not yet drained
  function automatic int unsigned pending(int unsigned filled, int unsigned drained);
    return filled - drained;
  endfunction

  function automatic bit count_ok(int unsigned cnt, int unsigned max_sect);
    return (cnt >= 1) && (cnt <= max_sect);
  endfunction

endpackage

// File: rtl/srp_ctrl.sv
module srp_ctrl #(
  parameter int SLOTS    = 4,
  parameter int MAX_SECT = 8,
  parameter int CNT_W    = 4,
  parameter int SLOT_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  sec_count,
  input  logic              chk_en_req,
  input  logic              fill_active,
  input  logic              fill_done,
  input  logic              drain_active,
  input  logic              drain_done,
  output logic              busy,
  output logic              chk_en,
  output logic              done,
  output logic              fill_go,
  output logic [SLOT_W-1:0] fill_slot,
  output logic [CNT_W-1:0]  fill_idx,
  output logic              drain_go,
  output logic [SLOT_W-1:0] drain_slot,
  output logic [CNT_W-1:0]  drain_idx
);
  import srp_pkg::*;

  logic             run_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] fill_idx_q;
  logic [CNT_W-1:0] drain_idx_q;
  logic             chk_q;
  logic             done_q;
  logic             start_ok;
  logic             last_drain;

  assign start_ok   = start && !run_q && count_ok(32'(sec_count), MAX_SECT);
  assign fill_go    = run_q && !fill_active && (fill_idx_q < total_q) &&
                      (pending(32'(fill_idx_q), 32'(drain_idx_q)) < SLOTS);
  assign drain_go   = run_q && !drain_active && (drain_idx_q < fill_idx_q);
  assign last_drain = drain_done && ((32'(drain_idx_q) + 1) == 32'(total_q));

  assign fill_slot  = SLOT_W'(slot_of(32'(fill_idx_q), SLOTS));
  assign drain_slot = SLOT_W'(slot_of(32'(drain_idx_q), SLOTS));
  assign fill_idx   = fill_idx_q;
  assign drain_idx  = drain_idx_q;
  assign busy       = run_q;
  assign chk_en     = chk_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      total_q     <= '0;
      fill_idx_q  <= '0;
      drain_idx_q <= '0;
      chk_q       <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        run_q       <= 1'b1;
        total_q     <= sec_count;
        chk_q       <= chk_en_req;
        fill_idx_q  <= '0;
        drain_idx_q <= '0;
      end else begin
        if (fill_done)  fill_idx_q  <= fill_idx_q + 1'b1;
        if (drain_done) drain_idx_q <= drain_idx_q + 1'b1;
        if (last_drain) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/srp_fill.sv
module srp_fill #(
  parameter int SECT_BYTES = 528,
  parameter int SLOT_W     = 2,
  parameter int OFF_W      = 10,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [SLOT_W-1:0] go_slot,
  input  logic [7:0]        nand_data,
  input  logic              nand_valid,
  output logic              nand_ready,
  output logic              fill_active,
  output logic              fill_done,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  import srp_pkg::*;

  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [OFF_W-1:0]  off_q;
  logic              accept;

  assign accept      = active_q && nand_valid;
  assign fill_done   = accept && sector_end(32'(off_q), SECT_BYTES);
  assign nand_ready  = active_q;
  assign fill_active = active_q;
  assign wr_en       = accept;
  assign wr_data     = nand_data;
  assign wr_addr     = ADDR_W'(byte_addr(32'(slot_q), 32'(off_q), SECT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      off_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      slot_q   <= go_slot;
      off_q    <= '0;
    end else if (accept) begin
      if (fill_done) active_q <= 1'b0;
      else           off_q    <= off_q + 1'b1;
    end
  end

endmodule

// File: rtl/srp_slot_mem.sv
module srp_slot_mem #(
  parameter int DEPTH  = 2112,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = store[rd_addr];

endmodule

// File: rtl/srp_drain.sv
module srp_drain #(
  parameter int DATA_BYTES = 512,
  parameter int SECT_BYTES = 528,
  parameter int SLOT_W     = 2,
  parameter int OFF_W      = 10,
  parameter int ADDR_W     = 12,
  parameter int SEC_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [SLOT_W-1:0] go_slot,
  input  logic [SEC_W-1:0]  go_sector,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_spare,
  output logic              out_last,
  output logic [SEC_W-1:0]  out_sector,
  output logic              drain_active,
  output logic              drain_done,
  output logic [ADDR_W-1:0] rd_addr
);
  import srp_pkg::*;

  logic              active_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SEC_W-1:0]  sector_q;
  logic [OFF_W-1:0]  off_q;
  logic              accept;

  assign accept       = active_q && out_ready;
  assign out_valid    = active_q;
  assign out_spare    = active_q && in_spare(32'(off_q), DATA_BYTES);
  assign out_last     = active_q && sector_end(32'(off_q), SECT_BYTES);
  assign out_sector   = sector_q;
  assign drain_active = active_q;
  assign drain_done   = accept && sector_end(32'(off_q), SECT_BYTES);
  assign rd_addr      = ADDR_W'(byte_addr(32'(slot_q), 32'(off_q), SECT_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      sector_q <= '0;
      off_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      slot_q   <= go_slot;
      sector_q <= go_sector;
      off_q    <= '0;
    end else if (accept) begin
      if (drain_done) active_q <= 1'b0;
      else            off_q    <= off_q + 1'b1;
    end
  end

endmodule

// File: rtl/sector_read_pipe.sv
module sector_read_pipe #(
  parameter int DATA_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int SLOTS       = 4,
  parameter int MAX_SECT    = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] sec_count,
  input  logic       chk_en_req,
  output logic       busy,
  output logic       chk_en,
  input  logic [7:0] nand_data,
  input  logic       nand_valid,
  output logic       nand_ready,
  output logic [7:0] out_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_spare,
  output logic       out_last,
  output logic [2:0] out_sector,
  output logic       done
);
  localparam int SECT_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int DEPTH      = SLOTS * SECT_BYTES;
  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int OFF_W      = $clog2(SECT_BYTES);
  localparam int SLOT_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int CNT_W      = 4;
  localparam int SEC_W      = 3;

  // internal events named for the bound checker
  logic              fill_go;
  logic              fill_active;
  logic              fill_done;
  logic [SLOT_W-1:0] fill_slot;
  logic [CNT_W-1:0]  fill_idx;
  logic              drain_go;
  logic              drain_active;
  logic              drain_done;
  logic [SLOT_W-1:0] drain_slot;
  logic [CNT_W-1:0]  drain_idx;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [ADDR_W-1:0] rd_addr;

  srp_ctrl #(
    .SLOTS(SLOTS), .MAX_SECT(MAX_SECT), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .sec_count(sec_count),
    .chk_en_req(chk_en_req), .fill_active(fill_active), .fill_done(fill_done),
    .drain_active(drain_active), .drain_done(drain_done), .busy(busy),
    .chk_en(chk_en), .done(done), .fill_go(fill_go), .fill_slot(fill_slot),
    .fill_idx(fill_idx), .drain_go(drain_go), .drain_slot(drain_slot),
    .drain_idx(drain_idx)
  );

  srp_fill #(
    .SECT_BYTES(SECT_BYTES), .SLOT_W(SLOT_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .go(fill_go), .go_slot(fill_slot),
    .nand_data(nand_data), .nand_valid(nand_valid), .nand_ready(nand_ready),
    .fill_active(fill_active), .fill_done(fill_done), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  srp_slot_mem #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(out_data)
  );

  srp_drain #(
    .DATA_BYTES(DATA_BYTES), .SECT_BYTES(SECT_BYTES), .SLOT_W(SLOT_W),
    .OFF_W(OFF_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .go(drain_go), .go_slot(drain_slot),
    .go_sector(SEC_W'(drain_idx)), .out_ready(out_ready), .out_valid(out_valid),
    .out_spare(out_spare), .out_last(out_last), .out_sector(out_sector),
    .drain_active(drain_active), .drain_done(drain_done), .rd_addr(rd_addr)
  );

endmodule

// File: rtl/srp_checker.sv
module srp_checker #(
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              chk_en,
  input logic              done,
  input logic              nand_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_last,
  input logic [7:0]        out_data,
  input logic              fill_go,
  input logic [SLOT_W-1:0] fill_slot,
  input logic [CNT_W-1:0]  fill_idx,
  input logic              drain_active,
  input logic [SLOT_W-1:0] drain_slot,
  input logic [CNT_W-1:0]  drain_idx
);

  AST_READY_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    nand_ready |-> busy); // R10

  AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_go && drain_active) |-> (fill_slot != drain_slot)); // R9

  AST_PENDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_idx - drain_idx) <= CNT_W'(SLOTS)); // R9

  AST_DRAIN_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (drain_idx < fill_idx)); // R7

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R12

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready && out_last)); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11

  AST_CHK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(chk_en)); // R4

endmodule

bind sector_read_pipe srp_checker #(
  .SLOTS(SLOTS), .CNT_W(CNT_W), .SLOT_W(SLOT_W)
) u_srp_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .chk_en(chk_en), .done(done),
  .nand_ready(nand_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_last(out_last), .out_data(out_data), .fill_go(fill_go),
  .fill_slot(fill_slot), .fill_idx(fill_idx), .drain_active(drain_active),
  .drain_slot(drain_slot), .drain_idx(drain_idx)
);

// File: tb/tb_sector_read_pipe.sv
module tb_sector_read_pipe;
  localparam int SECT = 528;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [3:0] sec_count;
  logic       chk_en_req;
  logic       busy, chk_en, nand_ready, out_valid, out_spare, out_last, done;
  logic [7:0] nand_data, out_data;
  logic       nand_valid, out_ready;
  logic [2:0] out_sector;

  int checks = 0;
  int fails  = 0;
  int run_id = 0;
  int wd     = 0;

  always #4 clk = ~clk;

  sector_read_pipe dut (
    .clk(clk), .rst_n(rst_n), .start(start), .sec_count(sec_count),
    .chk_en_req(chk_en_req), .busy(busy), .chk_en(chk_en),
    .nand_data(nand_data), .nand_valid(nand_valid), .nand_ready(nand_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_spare(out_spare), .out_last(out_last), .out_sector(out_sector),
    .done(done)
  );

  function automatic logic [7:0] byte_of(int rid, int idx);
    return 8'((idx * 37 + rid * 101 + (idx >> 3) * 13) ^ (idx >> 5));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 190000) begin
      fails++;
      $display("FAIL R11 watchdog actual=%0d expected=%0d", wd, 190000);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_case(int n, int vpct, int rpct, bit ce, int stall, bit poke);
    int  ncnt = 0;
    int  ocnt = 0;
    int  cyc  = 0;
    bit  overlap = 0;
    bit  last_hs = 0;
    bit  fin = 0;
    bit  hold_pend = 0;
    logic [7:0] hold_byte = 8'h00;
    run_id++;
    @(negedge clk);
    start = 1'b1; sec_count = 4'(n); chk_en_req = ce;
    nand_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 accept", int'(busy), 1);
    chk(chk_en == ce, "R4 capture", int'(chk_en), int'(ce));
    while (!fin && cyc < 40000) begin
      nand_valid = (($urandom % 100) < vpct);
      nand_data  = byte_of(run_id, ncnt);
      out_ready  = (cyc < stall) ? 1'b0 : (($urandom % 100) < rpct);
      if (poke && cyc == 30) begin
        start = 1'b1; sec_count = (n == 8) ? 4'd3 : 4'd8; chk_en_req = !ce;
      end else begin
        start = 1'b0;
      end
      #3;
      if (last_hs) begin
        chk(done && !busy, "R11 done pulse", int'(done), 1);
        fin = 1;
      end else if (done) begin
        chk(1'b0, "R11 early done", 1, 0);
      end
      if (hold_pend)
        chk(out_valid && out_data == hold_byte, "R12 hold", int'(out_data), int'(hold_byte));
      hold_pend = out_valid && !out_ready;
      hold_byte = out_data;
      if (nand_ready && out_valid) overlap = 1;
      if (nand_valid && nand_ready) begin
        chk(ncnt < n * SECT, "R10 excess intake", ncnt, n * SECT - 1);
        ncnt++;
      end
      chk(ncnt <= (ocnt / SECT + 4) * SECT, "R9 slot reuse", ncnt, (ocnt / SECT + 4) * SECT);
      if (out_valid && out_ready && !last_hs) begin
        chk(out_data == byte_of(run_id, ocnt), "R7 data", int'(out_data), int'(byte_of(run_id, ocnt)));
        chk(out_sector == 3'(ocnt / SECT), "R6 sector", int'(out_sector), ocnt / SECT);
        chk(out_spare == ((ocnt % SECT) >= 512), "R6 spare flag", int'(out_spare), int'((ocnt % SECT) >= 512));
        chk(out_last == ((ocnt % SECT) == SECT - 1), "R6 last flag", int'(out_last), int'((ocnt % SECT) == SECT - 1));
        ocnt++;
        if (ocnt == n * SECT) last_hs = 1;
      end
      if (stall > 0 && cyc == stall - 1) begin
        chk(ncnt == ((n < 4) ? n : 4) * SECT, "R9 four slots full", ncnt, ((n < 4) ? n : 4) * SECT);
        chk(!nand_ready, "R9 intake halted", int'(nand_ready), 0);
        chk(out_valid, "R5 first sector waiting", int'(out_valid), 1);
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0; nand_valid = 1'b0; out_ready = 1'b0;
    chk(fin, "R11 run finished", int'(fin), 1);
    chk(ncnt == n * SECT, "R10 intake total", ncnt, n * SECT);
    chk(ocnt == n * SECT, "R7 output total", ocnt, n * SECT);
    chk(chk_en == ce, "R4 held through run", int'(chk_en), int'(ce));
    if (poke) chk(ncnt == n * SECT, "R3 restart ignored", ncnt, n * SECT);
    if (n >= 2) chk(overlap, "R8 fill overlaps drain", int'(overlap), 1);
    #3;
    chk(!done && !busy && !nand_ready, "R11 single pulse", int'(done), 0);
  endtask

  task automatic bad_start(int cnt);
    logic prev;
    prev = chk_en;
    @(negedge clk);
    start = 1'b1; sec_count = 4'(cnt); chk_en_req = !prev;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !nand_ready, "R2 bad count ignored", int'(busy), 0);
    chk(chk_en == prev, "R4 no capture", int'(chk_en), int'(prev));
  endtask

  initial begin
    void'($urandom(32'h5EC7_0A11));
    rst_n = 1'b0; start = 1'b0; sec_count = 4'd0; chk_en_req = 1'b0;
    nand_data = 8'h00; nand_valid = 1'b0; out_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !nand_ready && !out_valid && !done && !chk_en, "R1 reset", int'(busy), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !nand_ready && !out_valid && !done && !chk_en, "R1 idle after reset", int'(out_valid), 0);

    bad_start(0);
    bad_start(9);
    run_case(1, 100, 100, 1'b1, 0, 1'b0);
    run_case(8, 80, 100, 1'b0, 4000, 1'b0);
    run_case(8, 75, 60, 1'b1, 0, 1'b1);
    run_case(4, 100, 100, 1'b0, 3000, 1'b0);
    run_case(2, 60, 30, 1'b1, 0, 1'b1);
    bad_start(15);
    for (int r = 0; r < 3; r++)
      run_case(1 + int'($urandom % 8), 40 + int'($urandom % 60),
               30 + int'($urandom % 70), 1'($urandom % 2), 0, 1'b0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule